// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Array

This block multiplies a stream of activation vectors by a square matrix of weights that stays resident inside a grid of N×N multiply-accumulate cells. Weights are first shifted into the grid column by column. Once every cell holds its weight, each accepted activation vector yields one output vector whose element j is the dot product of the vector with weight column j.

Inside the grid, activations step one cell to the right per clock and partial sums step one cell down per clock. Each cell touches only its immediate neighbours. The block skews each incoming vector into a diagonal wavefront, so grid row k sees its element k cycles late. It then re-aligns the column sums so that the whole result vector leaves on a single cycle. A host streams vectors back to back, one per clock. Rows that are offered while the weights are incomplete, or while a reload is running, are dropped.

Top module: `ws_matmul_grid`

## Requirements
- R1: While `wload_en` is high, every rising edge moves each cell's weight one row down its column, and lane j of `wload_data` (bits [8j+7:8j]) enters row 0 of column j. After N load edges, the cell at row k, column j holds lane j from load edge number N-1-k, counting from 0.
- R2: `wt_ready` rises after the N-th load edge counted since reset or since the last completed load. The first load edge of any later reload drops `wt_ready`, and it stays low until N load edges have occurred in total, even when the load is paused between edges.
- R3: A vector on `act_row` is accepted only on an edge where `act_valid` is high, `wt_ready` is high and `wload_en` is low. Any other offered vector produces no result at all.
- R4: For an accepted vector a, where a[k] is the signed 8-bit value in bits [8k+7:8k], output lane j (bits [SUM_W*j+SUM_W-1:SUM_W*j]) equals the sum over k of a[k]·W[k][j], with the weights signed.
- R5: `res_valid` and the result are visible after the (2N-1)-th rising edge that follows the accepting edge. There is exactly one valid cycle for each accepted vector, in acceptance order, and vectors accepted on consecutive cycles give results on consecutive cycles.
- R6: Sums are two's complement in SUM_W bits and wrap modulo 2^SUM_W without saturation.
- R7: While and right after reset, `res_valid`, `res_data` and `wt_ready` are all zero.
- R8: The weights stay unchanged between loads, so any number of passes can reuse a single load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wload_en | input | 1 | Shift the weight columns down by one row |
| wload_data | input | N*DATA_W | One weight per column, entering row 0 |
| act_valid | input | 1 | An activation vector is offered |
| act_row | input | N*DATA_W | Activation vector, element k goes to grid row k |
| wt_ready | output | 1 | All cells hold a complete weight set |
| res_valid | output | 1 | `res_data` carries one result vector |
| res_data | output | N*SUM_W | Column sums, lane j for column j |

## Verification
The hardest situations to reach are the ones where a vector is offered while the grid is only partly loaded. This happens during a reload that has already cleared `wt_ready`, and during a load that pauses partway and then resumes. In both cases the bench holds `act_valid` high on every load edge and inside the pause. It then shows that none of those vectors returns a result, and that the grid nonetheless ends up with the intended weights. Sum wrap cannot occur with 8-bit operands at the default width, so a second instance with 16-bit sums receives the same stimulus and is driven with extreme operands until its sums wrap.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int unsigned WSG_DATA_W = 8;
  localparam int unsigned WSG_SUM_W  = 32;
  localparam int unsigned WSG_DIM    = 4;
endpackage

// File: rtl/wsg_delay.sv
module wsg_delay #(
  parameter int unsigned W = 8,
  parameter int unsigned D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [D];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(D); i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < int'(D); i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[D-1];
endmodule

// File: rtl/wsg_cell.sv
module wsg_cell #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] act_in,
  input  logic [SW-1:0] psum_in,
  output logic [DW-1:0] w_out,
  output logic [DW-1:0] act_out,
  output logic [SW-1:0] psum_out
);
  logic [DW-1:0]          w_q;
  logic [DW-1:0]          act_q;
  logic [SW-1:0]          ps_q;
  logic signed [2*DW-1:0] prod;
  logic signed [SW-1:0]   prod_ext;

  assign prod     = $signed(w_q) * $signed(act_in);
  assign prod_ext = SW'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      act_q <= '0;
      ps_q  <= '0;
    end else begin
      if (ld) w_q <= w_in;
      act_q <= act_in;
      ps_q  <= psum_in + prod_ext;
    end
  end

  assign w_out    = w_q;
  assign act_out  = act_q;
  assign psum_out = ps_q;

  AST_WEIGHT_HELD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(w_out)); // R8

  AST_ZERO_ACT_PASS: assert property (@(posedge clk) disable iff (rst)
    (act_in == '0) |=> (psum_out == $past(psum_in))); // R4
endmodule

// File: rtl/ws_matmul_grid.sv
module ws_matmul_grid
  import wsg_pkg::*;
#(
  parameter int unsigned N      = WSG_DIM,
  parameter int unsigned DATA_W = WSG_DATA_W,
  parameter int unsigned SUM_W  = WSG_SUM_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wload_en,
  input  logic [N*DATA_W-1:0] wload_data,
  input  logic                act_valid,
  input  logic [N*DATA_W-1:0] act_row,
  output logic                wt_ready,
  output logic                res_valid,
  output logic [N*SUM_W-1:0]  res_data
);
  localparam int unsigned CW  = $clog2(N + 1);
  localparam int unsigned LAT = 2 * N;

  // weight load counter
  logic [CW-1:0] ld_cnt, ld_cnt_nxt;
  logic          ready_q;

  always_comb begin
    ld_cnt_nxt = ld_cnt;
    if (wload_en) ld_cnt_nxt = (ld_cnt == CW'(N)) ? CW'(1) : ld_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt  <= '0;
      ready_q <= 1'b0;
    end else begin
      ld_cnt  <= ld_cnt_nxt;
      ready_q <= (ld_cnt_nxt == CW'(N));
    end
  end

  assign wt_ready = ready_q;

  // acceptance and zero gating of idle slots
  logic                take;
  logic [N*DATA_W-1:0] act_gated;
  assign take      = act_valid & ready_q & ~wload_en;
  assign act_gated = take ? act_row : '0;

  logic [DATA_W-1:0] act_h [N][N+1];
  logic [DATA_W-1:0] w_v   [N+1][N];
  logic [SUM_W-1:0]  ps_v  [N+1][N];
  logic [SUM_W-1:0]  col_al [N];
  logic [N*DATA_W-1:0] unused_act_edge;
  logic [N*DATA_W-1:0] unused_w_edge;

  genvar k, j;
  generate
    for (k = 0; k < N; k++) begin : g_skew
      if (k == 0) begin : g_direct
        assign act_h[k][0] = act_gated[k*DATA_W +: DATA_W];
      end else begin : g_delay
        wsg_delay #(.W(DATA_W), .D(k)) u_skew (
          .clk(clk), .rst(rst),
          .din(act_gated[k*DATA_W +: DATA_W]),
          .dout(act_h[k][0]));
      end
      assign unused_act_edge[k*DATA_W +: DATA_W] = act_h[k][N];
    end

    for (j = 0; j < N; j++) begin : g_colio
      assign w_v[0][j]  = wload_data[j*DATA_W +: DATA_W];
      assign ps_v[0][j] = '0;
      assign unused_w_edge[j*DATA_W +: DATA_W] = w_v[N][j];
    end

    for (k = 0; k < N; k++) begin : g_row
      for (j = 0; j < N; j++) begin : g_col
        wsg_cell #(.DW(DATA_W), .SW(SUM_W)) u_cell (
          .clk(clk), .rst(rst), .ld(wload_en),
          .w_in(w_v[k][j]), .act_in(act_h[k][j]), .psum_in(ps_v[k][j]),
          .w_out(w_v[k+1][j]), .act_out(act_h[k][j+1]),
          .psum_out(ps_v[k+1][j]));
      end
    end

    for (j = 0; j < N; j++) begin : g_deskew
      if (j == N - 1) begin : g_direct
        assign col_al[j] = ps_v[N][j];
      end else begin : g_delay
        wsg_delay #(.W(SUM_W), .D(N - 1 - j)) u_align (
          .clk(clk), .rst(rst), .din(ps_v[N][j]), .dout(col_al[j]));
      end
    end
  endgenerate

  // result register
  logic [N*SUM_W-1:0] res_q;
  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else for (int c = 0; c < int'(N); c++) res_q[c*SUM_W +: SUM_W] <= col_al[c];
  end
  assign res_data = res_q;

  wsg_delay #(.W(1), .D(LAT)) u_vpipe (
    .clk(clk), .rst(rst), .din(take), .dout(res_valid));

  AST_READY_DROP_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(wt_ready) |-> $past(wload_en)); // R2

  AST_READY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(wt_ready) |-> $past(wload_en)); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ld_cnt <= CW'(N)); // R2
endmodule

// File: tb/ws_matmul_grid_test.sv
`timescale 1ns/1ps
module ws_matmul_grid_test;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int SW  = 32;
  localparam int SWN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wload_en = 1'b0;
  logic [N*DW-1:0] wload_data = '0;
  logic act_valid = 1'b0;
  logic [N*DW-1:0] act_row = '0;
  logic wt_ready, res_valid, wt_ready_n, res_valid_n;
  logic [N*SW-1:0]  res_data;
  logic [N*SWN-1:0] res_data_n;

  always #2.5 clk = ~clk;

  ws_matmul_grid #(.N(N), .DATA_W(DW), .SUM_W(SW)) uut (
    .clk(clk), .rst(rst), .wload_en(wload_en), .wload_data(wload_data),
    .act_valid(act_valid), .act_row(act_row), .wt_ready(wt_ready),
    .res_valid(res_valid), .res_data(res_data));

  ws_matmul_grid #(.N(N), .DATA_W(DW), .SUM_W(SWN)) uut_w (
    .clk(clk), .rst(rst), .wload_en(wload_en), .wload_data(wload_data),
    .act_valid(act_valid), .act_row(act_row), .wt_ready(wt_ready_n),
    .res_valid(res_valid_n), .res_data(res_data_n));

  int total = 0, bad = 0, cyc = 0;
  int wm [N][N];
  logic [N*SW-1:0]  exp_d [0:255];
  logic [N*SWN-1:0] exp_n [0:255];
  int exp_t [0:255];
  int wr = 0, rd = 0, lc = 0;
  bit ready_exp = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] got, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, expv);
    end
  endtask

  task automatic push_exp(input logic [N*DW-1:0] row);
    logic [N*SW-1:0] e32;
    logic [N*SWN-1:0] e16;
    for (int j = 0; j < N; j++) begin
      int s = 0;
      for (int k = 0; k < N; k++) s += int'($signed(row[k*DW +: DW])) * wm[k][j];
      e32[j*SW +: SW]   = s[31:0];
      e16[j*SWN +: SWN] = s[15:0];
    end
    exp_d[wr % 256] = e32;
    exp_n[wr % 256] = e16;
    exp_t[wr % 256] = cyc + 2 * N;
    wr++;
  endtask

  task automatic drive(input bit v, input logic [N*DW-1:0] row,
                       input bit wl, input logic [N*DW-1:0] wd);
    @(negedge clk);
    act_valid = v; act_row = row; wload_en = wl; wload_data = wd;
    if (v && ready_exp && !wl) push_exp(row);
    if (wl) begin
      lc = (lc == N) ? 1 : lc + 1;
      ready_exp = (lc == N);
    end
  endtask

  function automatic logic [N*DW-1:0] mkrow(input int seed);
    logic [N*DW-1:0] r;
    for (int k = 0; k < N; k++) r[k*DW +: DW] = 8'((seed * 53 + k * 29 + 7) & 255);
    return r;
  endfunction

  function automatic logic [N*DW-1:0] wrow(input int k);
    logic [N*DW-1:0] r;
    for (int j = 0; j < N; j++) r[j*DW +: DW] = 8'(wm[k][j]);
    return r;
  endfunction

  // result monitor: data, narrow wrap copy and latency
  always @(negedge clk) begin
    if (!rst && (res_valid || res_valid_n)) begin
      check(res_valid === res_valid_n, "R6", "valid alignment of narrow copy",
            128'(res_valid_n), 128'(res_valid));
      if (rd == wr) begin
        check(1'b0, "R3", "result with no accepted vector", 128'(res_data), 128'(0));
      end else begin
        check(res_data === exp_d[rd % 256], "R1,R4", "column sums",
              128'(res_data), 128'(exp_d[rd % 256]));
        check(res_data_n === exp_n[rd % 256], "R6", "wrapped 16-bit sums",
              128'(res_data_n), 128'(exp_n[rd % 256]));
        check(cyc == exp_t[rd % 256], "R5", "result cycle",
              128'(cyc), 128'(exp_t[rd % 256]));
        rd++;
      end
    end
  end

  task automatic drain;
    repeat (2 * N + 3) drive(1'b0, '0, 1'b0, '0);
    check(rd == wr, "R5", "every accepted vector returned", 128'(rd), 128'(wr));
  endtask

  task automatic load_weights;
    for (int c = 0; c < N; c++) begin
      drive(1'b0, '0, 1'b1, wrow(N - 1 - c));
      if (c == N - 1 && N > 1)
        check(wt_ready == 1'b0, "R2", "ready low before last load edge", 128'(wt_ready), 128'(0));
    end
    drive(1'b0, '0, 1'b0, '0);
    check(wt_ready == 1'b1, "R2", "ready after N load edges", 128'(wt_ready), 128'(1));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && res_data == '0, "R7", "outputs in reset",
          128'(res_data), 128'(0));
    check(wt_ready == 1'b0, "R7", "ready in reset", 128'(wt_ready), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && res_data == '0 && wt_ready == 1'b0, "R7",
          "outputs after reset", 128'(res_data), 128'(0));
    // vectors offered with no weights loaded must vanish
    for (int i = 0; i < 3; i++) drive(1'b1, mkrow(i + 100), 1'b0, '0);
    drain();
  endtask

  task automatic t_identity;
    for (int k = 0; k < N; k++) for (int j = 0; j < N; j++) wm[k][j] = (k == j) ? 1 : 0;
    load_weights();
    for (int i = 0; i < 3; i++) drive(1'b1, mkrow(i), 1'b0, '0);
    drain();
  endtask

  task automatic t_general_stream;
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++) wm[k][j] = ((k * 7 + j * 13 + 3) % 256) - 128;
    wm[0][0] = -128; wm[N-1][N-1] = 127; wm[0][N-1] = 5; wm[N-1][0] = -3;
    load_weights();
    for (int i = 0; i < 8; i++) drive(1'b1, mkrow(i * 3 + 11), 1'b0, '0);
    drain();
  endtask

  task automatic t_gaps_reuse;
    // R8: no reload, weights from previous pass reused
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, mkrow(i + 40), 1'b0, '0);
      if (i % 2 == 1) repeat (i) drive(1'b0, mkrow(99), 1'b0, '0);
    end
    drain();
  endtask

  task automatic t_ignore_during_load;
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++) wm[k][j] = (k + 1) * (j - 2);
    // first two load edges with vectors offered on each
    for (int c = 0; c < 2; c++) drive(1'b1, mkrow(c + 60), 1'b1, wrow(N - 1 - c));
    // pause: still not ready, offered vectors ignored
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, mkrow(i + 70), 1'b0, '0);
      check(wt_ready == 1'b0, "R2", "ready low in paused reload", 128'(wt_ready), 128'(0));
    end
    for (int c = 2; c < N; c++) drive(1'b1, mkrow(c + 80), 1'b1, wrow(N - 1 - c));
    drive(1'b0, '0, 1'b0, '0);
    check(wt_ready == 1'b1, "R2", "ready after resumed load", 128'(wt_ready), 128'(1));
    drain();
    check(wr == rd, "R3", "no vector accepted during load", 128'(rd), 128'(wr));
    for (int i = 0; i < 4; i++) drive(1'b1, mkrow(i + 90), 1'b0, '0);
    drain();
  endtask

  task automatic t_wrap;
    logic [N*DW-1:0] r;
    for (int k = 0; k < N; k++) for (int j = 0; j < N; j++) wm[k][j] = -128;
    load_weights();
    for (int k = 0; k < N; k++) r[k*DW +: DW] = 8'h80;
    drive(1'b1, r, 1'b0, '0);           // 65536: wraps to 0 in 16 bits
    for (int k = 0; k < N; k++) r[k*DW +: DW] = 8'h7F;
    drive(1'b1, r, 1'b0, '0);           // -65024: wraps in 16 bits
    drain();
  endtask

  initial begin
    t_reset();
    t_identity();
    t_general_stream();
    t_gaps_reuse();
    t_ignore_during_load();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule